// File: doc/BRIEF.md
# Event Timer Register Block

This block is the front end of a multi-channel event timer. It owns a free-running 32-bit main counter, a global configuration word and a read-only capability word, and it decodes a small memory-mapped register window on behalf of a set of comparator channels that live in separate blocks. The counter advances by one on every cycle in which the prescaler presents a tick, but only while the global enable bit is set; otherwise it holds its value.

Software reaches the block through a single-cycle request bus carrying an address, an access size in bytes, write data and byte lanes. Only 4-byte and 8-byte accesses that are aligned to their own size are honoured. A 4-byte access with address bit 2 set addresses the upper half of the 64-bit register. Read data is registered and appears the cycle after the request. Channel registers are not stored here. The block drives a one-hot channel select, a field code and a write strobe, together with the write data and lane mask already placed in the 64-bit register. It returns whatever word the selected channel supplies on a shared read input. A one-cycle restart pulse tells the channels to re-arm from the current counter value.

Top module: `evtmr_regs`

## Requirements
- R1: A request is honoured only when its size is 4 with address bits 1:0 zero, or 8 with address bits 2:0 zero. Any other write changes no register and raises no strobe. Any other read returns zero.
- R2: Read data appears on `rd_data` in the cycle after the read request. A 4-byte read with address bit 2 clear returns the low 32 bits of the register, zero-extended. With bit 2 set, it returns the upper 32 bits shifted down to bits 31:0. A 4-byte write with bit 2 set lands in register bits 63:32.
- R3: The capability word at offset 0x000 holds the following fields, all other bits zero: revision 1 in bits 7:0, channel count minus one in bits 12:8, bit 13 clear to mark a 32-bit counter, the vendor code in bits 31:16, and the tick period in femtoseconds in bits 63:32. With the defaults this is 0x05F5E100_C0DE0701. Writes to it have no effect.
- R4: The configuration word at offset 0x010 stores written bits. Bit 0 enables counting. Bit 1, the legacy routing bit, always reads back zero after any write.
- R5: The main counter at offset 0x0F0 advances by exactly one per tick while enabled. It holds its value while disabled, whatever the tick input does.
- R6: A counter write merges the written lanes into the zero-extended current value and keeps the low 32 bits. A write to the upper half leaves the count unchanged. The upper half always reads zero. A write takes precedence over a tick in the same cycle.
- R7: `restart` pulses for one cycle after the enable bit goes from 0 to 1, and after a counter write made while enabled. A counter write made while disabled does not raise it.
- R8: Reads of unmapped offsets return zero. This includes 0x008, 0x0F8, the fourth slot (+0x18) of a channel, and any offset past the last channel.
- R9: Channel n occupies 0x100+0x20·n. Its fields sit at +0x00 (code 0, config), +0x08 (code 1, comparator) and +0x10 (code 2, message route). For a mapped field, `tmr_sel` is one-hot on n and `tmr_field` carries the code. A write also raises `tmr_we` with the positioned data and mask on `fwd_data`/`fwd_mask`. A read returns `tmr_rdata`.
- R10: A read at offset 0x020 returns `irq_status` zero-extended. A write there raises `stat_we` with the forwarded data and mask.
- R11: Writes are read-modify-write under the lane mask. Bytes whose lane bit is clear keep their old value. For 4-byte accesses only lanes 3:0 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| bus_lanes | input | 8 | Byte lane enables |
| rd_data | output | 64 | Registered read data |
| tick | input | 1 | Prescaler tick |
| irq_status | input | NUM_TMR | Per-channel interrupt status from delivery logic |
| tmr_rdata | input | 64 | Word of the selected channel field |
| count_val | output | 32 | Current main counter |
| count_en | output | 1 | Counter enable |
| restart | output | 1 | Channel re-arm pulse |
| tmr_sel | output | NUM_TMR | One-hot channel select |
| tmr_field | output | 2 | Field code within the channel |
| tmr_we | output | 1 | Channel field write strobe |
| stat_we | output | 1 | Interrupt status write strobe |
| fwd_data | output | 64 | Write data placed in the 64-bit register |
| fwd_mask | output | 64 | Bit mask of the written bytes |

## Verification
The hardest situation to reach is the one where the counter moves and the bus writes it at once. This includes a tick landing while the counter is disabled, and a counter write arriving while the counter runs. The restart pulse also depends on whether enable was already set. The stimulus walks the counter through the following states and reads it back after each: written while off, enabled, ticked, rewritten while running, disabled, then ticked again. This shows both that the holding works and that the restart pulse appears only when it should. Misaligned and odd-sized requests are aimed at live registers, so a dropped write shows up as an unchanged read.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    localparam int OFF_CAP   = 'h000;
    localparam int OFF_CFG   = 'h010;
    localparam int OFF_STAT  = 'h020;
    localparam int OFF_CNT   = 'h0F0;
    localparam int TMR_BASE  = 'h100;
    localparam int TMR_SPAN  = 'h20;
    localparam int CFG_EN    = 0;
    localparam int CFG_LEGACY = 1;

    typedef enum logic [2:0] {
        RG_NONE, RG_CAP, RG_CFG, RG_STAT, RG_CNT, RG_TMR
    } region_t;

    typedef enum logic [1:0] {
        TF_CFG = 2'd0, TF_CMP = 2'd1, TF_ROUTE = 2'd2, TF_NONE = 2'd3
    } tfield_t;

    typedef struct packed {
        logic        ok;
        logic        half;
        logic        upper;
        region_t     rg;
        tfield_t     fld;
        logic [63:0] data;
        logic [63:0] mask;
    } access_t;

    function automatic logic [63:0] lane_expand(input logic [7:0] ln);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{ln[i]}};
        return m;
    endfunction

    function automatic logic [63:0] merge64(input logic [63:0] old,
                                            input logic [63:0] d,
                                            input logic [63:0] m);
        return (old & ~m) | (d & m);
    endfunction

endpackage

// File: rtl/evtmr_decode.sv
module evtmr_decode
    import evtmr_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_TMR = 8
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic [63:0]       wdata,
    input  logic [7:0]        lanes,
    output access_t           acc,
    output logic [NUM_TMR-1:0] sel
);
    localparam int TMR_END = TMR_BASE + NUM_TMR * TMR_SPAN;

    logic [31:0] off32;
    logic [31:0] rel;
    logic        in_tmr;
    logic [63:0] half_mask;

    assign off32  = 32'({addr[ADDR_W-1:3], 3'b000});
    assign rel    = off32 - 32'(TMR_BASE);
    assign in_tmr = (off32 >= 32'(TMR_BASE)) && (off32 < 32'(TMR_END));
    assign half_mask = {32'b0, lane_expand({4'b0, lanes[3:0]})[31:0]};

    always_comb begin
        acc.half  = (size == 4'd4);
        acc.upper = addr[2];
        acc.ok    = valid && ((size == 4'd4 && addr[1:0] == 2'b00) ||
                              (size == 4'd8 && addr[2:0] == 3'b000));
        if (acc.half) begin
            acc.data = addr[2] ? {wdata[31:0], 32'b0} : {32'b0, wdata[31:0]};
            acc.mask = addr[2] ? {half_mask[31:0], 32'b0} : half_mask;
        end else begin
            acc.data = wdata;
            acc.mask = lane_expand(lanes);
        end
        acc.fld = TF_NONE;
        if (!acc.ok)                      acc.rg = RG_NONE;
        else if (off32 == 32'(OFF_CAP))   acc.rg = RG_CAP;
        else if (off32 == 32'(OFF_CFG))   acc.rg = RG_CFG;
        else if (off32 == 32'(OFF_STAT))  acc.rg = RG_STAT;
        else if (off32 == 32'(OFF_CNT))   acc.rg = RG_CNT;
        else if (in_tmr) begin
            acc.rg  = RG_TMR;
            acc.fld = tfield_t'(rel[4:3]);
        end else                          acc.rg = RG_NONE;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_sel
        assign sel[g] = (acc.rg == RG_TMR) && (acc.fld != TF_NONE) &&
                        (rel[31:5] == 27'(g));
    end

    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(sel)); // R9
    end

endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter
    import evtmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cnt_we,
    input  logic        tick,
    input  logic [63:0] data,
    input  logic [63:0] mask,
    output logic [63:0] cfg_q,
    output logic [31:0] cnt_q,
    output logic        restart
);
    logic [63:0] cfg_next;
    logic [63:0] cnt_merge;
    logic        en;

    assign en = cfg_q[CFG_EN];

    always_comb begin
        cfg_next = merge64(cfg_q, data, mask);
        cfg_next[CFG_LEGACY] = 1'b0;
        cnt_merge = merge64({32'b0, cnt_q}, data, mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cnt_q   <= '0;
            restart <= 1'b0;
        end else begin
            restart <= 1'b0;
            if (cfg_we) begin
                cfg_q <= cfg_next;
                if (cfg_next[CFG_EN] && !en) restart <= 1'b1;
            end
            if (cnt_we) begin
                cnt_q <= cnt_merge[31:0];
                if (en) restart <= 1'b1;
            end else if (en && tick) begin
                cnt_q <= cnt_q + 32'd1;
            end
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_we) |=> $stable(cnt_q)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !cnt_we) |=> (cnt_q == $past(cnt_q) + 32'd1)); // R5
    AST_RESTART_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> restart); // R7
    AST_RESTART_WR: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && en) |=> restart); // R7
    AST_NO_RESTART_OFF: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && !en && !cfg_we) |=> !restart); // R7

endmodule

// File: rtl/evtmr_regs.sv
module evtmr_regs
    import evtmr_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_TMR   = 8,
    parameter logic [15:0] VENDOR    = 16'hC0DE,
    parameter logic [31:0] PERIOD_FS = 32'd100000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_size,
    input  logic [63:0]        bus_wdata,
    input  logic [7:0]         bus_lanes,
    output logic [63:0]        rd_data,
    input  logic               tick,
    input  logic [NUM_TMR-1:0] irq_status,
    input  logic [63:0]        tmr_rdata,
    output logic [31:0]        count_val,
    output logic               count_en,
    output logic               restart,
    output logic [NUM_TMR-1:0] tmr_sel,
    output logic [1:0]         tmr_field,
    output logic               tmr_we,
    output logic               stat_we,
    output logic [63:0]        fwd_data,
    output logic [63:0]        fwd_mask
);
    localparam logic [4:0]  TMR_CNT_FLD = 5'(NUM_TMR - 1);
    localparam logic [63:0] CAP_WORD =
        {PERIOD_FS, VENDOR, 3'b000, TMR_CNT_FLD, 8'd1};

    access_t     acc;
    logic        wr, rd;
    logic        cfg_we, cnt_we;
    logic [63:0] cfg_q;
    logic [63:0] word;
    logic [63:0] rd_next;

    evtmr_decode #(.ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR)) u_dec (
        .valid (bus_valid),
        .addr  (bus_addr),
        .size  (bus_size),
        .wdata (bus_wdata),
        .lanes (bus_lanes),
        .acc   (acc),
        .sel   (tmr_sel)
    );

    assign wr     = acc.ok && bus_write;
    assign rd     = bus_valid && !bus_write;
    assign cfg_we = wr && (acc.rg == RG_CFG);
    assign cnt_we = wr && (acc.rg == RG_CNT);
    assign stat_we = wr && (acc.rg == RG_STAT);
    assign tmr_we = wr && (acc.rg == RG_TMR) && (acc.fld != TF_NONE);
    assign tmr_field = acc.fld;
    assign fwd_data = acc.data;
    assign fwd_mask = acc.mask;

    evtmr_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (cfg_we),
        .cnt_we  (cnt_we),
        .tick    (tick),
        .data    (acc.data),
        .mask    (acc.mask),
        .cfg_q   (cfg_q),
        .cnt_q   (count_val),
        .restart (restart)
    );

    assign count_en = cfg_q[CFG_EN];

    always_comb begin
        unique case (acc.rg)
            RG_CAP:  word = CAP_WORD;
            RG_CFG:  word = cfg_q;
            RG_STAT: word = 64'(irq_status);
            RG_CNT:  word = {32'b0, count_val};
            RG_TMR:  word = (acc.fld != TF_NONE) ? tmr_rdata : 64'b0;
            default: word = 64'b0;
        endcase
        if (!acc.ok)       rd_next = 64'b0;
        else if (acc.half) rd_next = acc.upper ? {32'b0, word[63:32]}
                                               : {32'b0, word[31:0]};
        else               rd_next = word;
    end

    always_ff @(posedge clk) begin
        if (rst)     rd_data <= '0;
        else if (rd) rd_data <= rd_next;
    end

    AST_BAD_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !acc.ok) |-> !(tmr_we || stat_we || cfg_we || cnt_we)); // R1
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !acc.ok) |=> (rd_data == 64'b0)); // R1
    AST_LEGACY_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !cfg_q[CFG_LEGACY]); // R4

endmodule

// File: tb/evtmr_regs_test.sv
module evtmr_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_valid = 0, bus_write = 0;
    logic [11:0] bus_addr = 0;
    logic [3:0]  bus_size = 0;
    logic [63:0] bus_wdata = 0;
    logic [7:0]  bus_lanes = 0;
    logic [63:0] rd_data;
    logic        tick = 0;
    logic [N-1:0] irq_status = 8'h5A;
    logic [63:0] tmr_rdata;
    logic [31:0] count_val;
    logic        count_en, restart, tmr_we, stat_we;
    logic [N-1:0] tmr_sel;
    logic [1:0]  tmr_field;
    logic [63:0] fwd_data, fwd_mask;

    int errors = 0;
    int checks = 0;
    logic        rd_pend = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    evtmr_regs uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_lanes(bus_lanes), .rd_data(rd_data), .tick(tick),
        .irq_status(irq_status), .tmr_rdata(tmr_rdata), .count_val(count_val),
        .count_en(count_en), .restart(restart), .tmr_sel(tmr_sel),
        .tmr_field(tmr_field), .tmr_we(tmr_we), .stat_we(stat_we),
        .fwd_data(fwd_data), .fwd_mask(fwd_mask)
    );

    // channel model: word = A0.. | index<<8 | field
    always_comb begin
        tmr_rdata = 64'hA000_0000_0000_0000 | 64'(tmr_field);
        for (int i = 0; i < N; i++)
            if (tmr_sel[i]) tmr_rdata = tmr_rdata | (64'(i) << 8);
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) rd_pend <= bus_valid && !bus_write;
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            automatic logic [63:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, rd_data, e);
        end
    end

    task automatic wr_start(input logic [11:0] a, input logic [3:0] sz,
                            input logic [63:0] d, input logic [7:0] ln);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_size = sz;
        bus_wdata = d; bus_lanes = ln;
    endtask

    task automatic bus_end();
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] sz,
                      input logic [63:0] d, input logic [7:0] ln);
        wr_start(a, sz, d, ln);
        bus_end();
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] sz,
                      input logic [63:0] e, input string req);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(req);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = sz;
        bus_end();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // reset state
        check("R5 reset count", 64'(count_val), 64'h0);
        check("R7 reset restart", 64'(restart), 64'h0);
        rd(12'h010, 4'd8, 64'h0, "R4 reset cfg");

        // R3 capability
        rd(12'h000, 4'd8, 64'h05F5E100_C0DE0701, "R3 cap 8-byte");
        rd(12'h004, 4'd4, 64'h05F5E100, "R2 R3 cap upper half");
        rd(12'h000, 4'd4, 64'hC0DE0701, "R2 R3 cap lower half");
        wr(12'h000, 4'd8, 64'h0, 8'hFF);
        rd(12'h000, 4'd8, 64'h05F5E100_C0DE0701, "R3 cap write ignored");

        // R11 lanes, R4 legacy bit
        wr(12'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 8'h02);
        rd(12'h010, 4'd8, 64'hFF00, "R11 lane 1 only");
        wr(12'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE, 8'h01);
        rd(12'h010, 4'd8, 64'hFFFC, "R4 legacy bit reads zero");

        // R1 bad requests
        wr(12'h014, 4'd8, 64'h1, 8'hFF);
        wr(12'h010, 4'd2, 64'h1, 8'hFF);
        wr(12'h012, 4'd4, 64'h1, 8'hFF);
        rd(12'h010, 4'd8, 64'hFFFC, "R1 bad writes dropped");
        check("R1 not enabled", 64'(count_en), 64'h0);
        wr_start(12'h104, 4'd8, 64'h1, 8'hFF); #1;
        check("R1 no tmr strobe", 64'(tmr_we), 64'h0);
        bus_end();
        rd(12'h004, 4'd8, 64'h0, "R1 misaligned read");
        rd(12'h000, 4'd2, 64'h0, "R1 size 2 read");

        // R8 unmapped
        rd(12'h008, 4'd8, 64'h0, "R8 0x008");
        rd(12'h0F8, 4'd8, 64'h0, "R8 0x0F8");
        rd(12'h1F8, 4'd8, 64'h0, "R8 channel slot 3");
        rd(12'h200, 4'd8, 64'h0, "R8 past last channel");

        // R9 channel reads and write strobe
        rd(12'h140, 4'd8, 64'hA000_0000_0000_0200, "R9 ch2 cfg");
        rd(12'h168, 4'd8, 64'hA000_0000_0000_0301, "R9 ch3 cmp");
        rd(12'h1F0, 4'd8, 64'hA000_0000_0000_0702, "R9 ch7 route");
        rd(12'h16C, 4'd4, 64'hA0000000, "R9 R2 ch3 cmp upper half");
        wr_start(12'h12C, 4'd4, 64'hDEADBEEF, 8'h0F); #1;
        check("R9 tmr_we", 64'(tmr_we), 64'h1);
        check("R9 tmr_sel", 64'(tmr_sel), 64'h2);
        check("R9 tmr_field", 64'(tmr_field), 64'h1);
        check("R2 R9 fwd_data upper", fwd_data, 64'hDEADBEEF_00000000);
        check("R2 R9 fwd_mask upper", fwd_mask, 64'hFFFFFFFF_00000000);
        bus_end();

        // R10 status
        rd(12'h020, 4'd8, 64'h5A, "R10 status read");
        wr_start(12'h020, 4'd8, 64'h3, 8'hFF); #1;
        check("R10 stat_we", 64'(stat_we), 64'h1);
        check("R10 fwd_mask", fwd_mask, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_end();

        // R6 R7 counter written while disabled
        wr_start(12'h0F0, 4'd8, 64'hFFFF_0000_0000_1234, 8'hFF);
        bus_end();
        check("R7 no restart when off", 64'(restart), 64'h0);
        rd(12'h0F0, 4'd8, 64'h1234, "R6 counter write");
        rd(12'h0F4, 4'd4, 64'h0, "R6 upper half zero");
        wr(12'h0F4, 4'd4, 64'hFFFF, 8'h0F);
        rd(12'h0F0, 4'd8, 64'h1234, "R6 upper write no effect");
        ticks(3);
        rd(12'h0F0, 4'd8, 64'h1234, "R5 hold while disabled");

        // R7 enable
        wr_start(12'h010, 4'd4, 64'h1, 8'h01);
        bus_end();
        check("R7 restart on enable", 64'(restart), 64'h1);
        @(negedge clk);
        check("R7 restart one cycle", 64'(restart), 64'h0);
        check("R4 enabled", 64'(count_en), 64'h1);
        ticks(5);
        rd(12'h0F0, 4'd8, 64'h1239, "R5 five ticks");

        // R7 write while enabled
        wr_start(12'h0F0, 4'd8, 64'h50, 8'hFF);
        bus_end();
        check("R7 restart on running write", 64'(restart), 64'h1);
        rd(12'h0F0, 4'd8, 64'h50, "R6 written while running");
        // R6 write wins over tick
        @(negedge clk); tick = 1;
        bus_valid = 1; bus_write = 1; bus_addr = 12'h0F0; bus_size = 4'd8;
        bus_wdata = 64'h70; bus_lanes = 8'hFF;
        @(negedge clk); tick = 0; bus_valid = 0; bus_write = 0;
        check("R6 write beats tick", 64'(count_val), 64'h70);
        ticks(2);
        rd(12'h0F0, 4'd8, 64'h72, "R5 ticks after write");

        // disable then tick
        wr(12'h010, 4'd4, 64'h0, 8'h01);
        ticks(3);
        rd(12'h0F0, 4'd4, 64'h72, "R5 hold after disable");
        wr(12'h0F0, 4'd4, 64'hABCD, 8'h03);
        rd(12'h0F0, 4'd8, 64'hABCD, "R11 counter lane merge");

        // R2 upper half config write
        wr(12'h014, 4'd4, 64'hAA, 8'h01);
        rd(12'h010, 4'd8, 64'h000000AA_0000FF00, "R2 cfg upper write");
        rd(12'h014, 4'd4, 64'hAA, "R2 cfg upper read");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule